// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures how long a chosen low-frequency clock takes to run through a requested number of its own cycles, in cycles of the fast crystal clock that drives the block. Four slow clock inputs are available, and a 2-bit selector chooses one of them. Each slow input is brought into the fast domain through its own synchronizer, and its rising edges are detected there.

Software presents a source, a cycle request and a one-cycle start. Once the first synchronized rising edge of the chosen source arrives, the block counts fast cycles until that source has completed the requested number of periods. It then pulses done and returns the total, which software divides by the request to get an average period. Downstream code treats that average as a fixed-point value with 19 fractional bits.

A slow source that is dead or far too slow cannot hang the block. A threshold is formed by shifting the request left by a distance that depends on the source. If the run lasts that many fast cycles, it ends with a timeout flag and a result of zero.

Top module: `slow_cal_counter`

## Requirements
- R1: After reset, done, busy and timed_out are 0 and result is 0.
- R2: src_sel picks the measured input as slow_clk_i[src_sel]: bit 0 is the slow clock currently in use, bit 1 the 8 MHz RC divided by 256, bit 2 the external 32 kHz crystal, bit 3 the internal 150 kHz oscillator.
- R3: On a completed run, result is the number of fast cycles between the first synchronized rising edge after start and the rising edge that completes the requested number of slow periods. For a steady clock of period P fast cycles and a request of N, this is N*P.
- R4: The timeout threshold is the request shifted left by SHIFT_HI for src_sel 0, 1 and 2, and by SHIFT_LO for src_sel 3. It is clamped to the largest value result can hold.
- R5: If a run lasts L busy cycles after the start edge, where L is the threshold, and has not completed, done pulses with timed_out 1 and result 0. Done then appears L+1 clock edges after the edge that accepted start. A completion in that same cycle takes priority.
- R6: done is high for exactly one cycle. result and timed_out keep their values until the next accepted start.
- R7: A start raised while busy is ignored: the run in progress keeps its source, request and threshold.
- R8: A start with a request of 0 produces done on the next edge, with result 0 and timed_out 0, and busy never rises.
- R9: busy rises on the edge that accepts a start with a nonzero request. It falls on the edge that raises done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast crystal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk_i | input | 4 | The four slow clock inputs, indexed by src_sel |
| src_sel | input | 2 | Source to measure, sampled at start |
| start | input | 1 | Begins a run when the block is idle |
| cycles | input | CYC_W | Requested number of slow periods |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| timed_out | output | 1 | Last run hit its threshold |
| result | output | CNT_W | Fast-cycle total of the last run, or 0 after a timeout |

## Verification
The bench builds the block with CNT_W of 16, SHIFT_HI of 6 and SHIFT_LO of 4. With these values, timeouts happen after tens of cycles, so the same slow period can pass on a high-shift source and time out on the low-shift one. With a 16-bit result, a large request also drives the threshold into its clamp within the run budget. The slow clocks are generated as steady square waves locked to the fast clock, which makes every total an exact product of period and request.

// File: rtl/slow_cal_counter.sv
module slow_cal_counter #(
  parameter int CYC_W    = 15,
  parameter int CNT_W    = 32,
  parameter int SYNC_N   = 2,
  parameter int SHIFT_HI = 12,
  parameter int SHIFT_LO = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       slow_clk_i,
  input  logic [1:0]       src_sel,
  input  logic             start,
  input  logic [CYC_W-1:0] cycles,
  output logic             busy,
  output logic             done,
  output logic             timed_out,
  output logic [CNT_W-1:0] result
);
  localparam int NSRC = 4;
  localparam int LIM_W = CYC_W + SHIFT_HI;
  localparam logic [1:0] LO_SEL = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN} state_t;

  state_t state_q;
  logic [NSRC-1:0][SYNC_N-1:0] sync_q;
  logic [NSRC-1:0] prev_q, rise_vec;
  logic [1:0]       sel_q;
  logic [CYC_W-1:0] left_q;
  logic [CNT_W-1:0] limit_q, elapsed_q, count_q, res_q;
  logic             done_q, to_q;
  logic [LIM_W-1:0] lim_wide;
  logic [CNT_W-1:0] lim_val;
  logic             rise, finish, expire;

  for (genvar g = 0; g < NSRC; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q[g] <= '0;
        prev_q[g] <= 1'b0;
      end else begin
        sync_q[g] <= {sync_q[g][SYNC_N-2:0], slow_clk_i[g]};
        prev_q[g] <= sync_q[g][SYNC_N-1];
      end
    end
    assign rise_vec[g] = sync_q[g][SYNC_N-1] & ~prev_q[g];
  end

  assign lim_wide = (src_sel == LO_SEL) ? (LIM_W'(cycles) << SHIFT_LO)
                                        : (LIM_W'(cycles) << SHIFT_HI);

  if (LIM_W > CNT_W) begin : g_clamp
    assign lim_val = (|lim_wide[LIM_W-1:CNT_W]) ? '1 : lim_wide[CNT_W-1:0];
  end else begin : g_fit
    assign lim_val = CNT_W'(lim_wide);
  end

  assign rise   = rise_vec[sel_q];
  assign finish = (state_q == ST_RUN) && rise && (left_q == CYC_W'(1));
  assign expire = (state_q != ST_IDLE) && (elapsed_q >= limit_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sel_q     <= '0;
      left_q    <= '0;
      limit_q   <= '0;
      elapsed_q <= '0;
      count_q   <= '0;
      res_q     <= '0;
      to_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start) begin
          sel_q     <= src_sel;
          left_q    <= cycles;
          limit_q   <= lim_val;
          elapsed_q <= '0;
          count_q   <= '0;
          res_q     <= '0;
          to_q      <= 1'b0;
          if (cycles == '0) done_q <= 1'b1;
          else              state_q <= ST_ARM;
        end
      end else begin
        elapsed_q <= (&elapsed_q) ? elapsed_q : elapsed_q + 1'b1;
        if (finish) begin
          res_q   <= (&count_q) ? count_q : count_q + 1'b1;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end else if (expire) begin
          res_q   <= '0;
          to_q    <= 1'b1;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end else if (state_q == ST_ARM) begin
          if (rise) state_q <= ST_RUN;
        end else begin
          count_q <= (&count_q) ? count_q : count_q + 1'b1;
          if (rise) left_q <= left_q - 1'b1;
        end
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign timed_out = to_q;
  assign result    = res_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(result) && $stable(timed_out)));

  // R5
  zero_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timed_out) |-> (result == '0));

  // R8
  zero_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cycles == '0) |=> (done && !busy && !timed_out && result == '0));

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(limit_q));
endmodule

// File: tb/slow_cal_counter_test.sv
module slow_cal_counter_test;
  localparam int CYC_W = 15, CNT_W = 16, SHI = 6, SLO = 4;
  localparam longint MAXC = (64'd1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] slow = '0;
  logic [1:0] src_sel = '0;
  logic [CYC_W-1:0] cycles = '0;
  logic busy, done, timed_out;
  logic [CNT_W-1:0] result;

  int checks = 0, errors = 0, cyc = 0;
  int half [4] = '{4, 10, 16, 3};
  int pc   [4] = '{0, 0, 0, 0};
  bit freeze [4] = '{0, 0, 0, 0};

  slow_cal_counter #(.CYC_W(CYC_W), .CNT_W(CNT_W), .SYNC_N(2),
                     .SHIFT_HI(SHI), .SHIFT_LO(SLO)) uut (
    .clk(clk), .rst_n(rst_n), .slow_clk_i(slow), .src_sel(src_sel),
    .start(start), .cycles(cycles), .busy(busy), .done(done),
    .timed_out(timed_out), .result(result));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (!freeze[i]) begin
        if (pc[i] >= half[i] - 1) begin pc[i] = 0; slow[i] = ~slow[i]; end
        else pc[i] = pc[i] + 1;
      end
    end
  end

  // behavioural reference
  int ph = 0, m_sel = 0;
  longint m_left, m_lim, m_el, m_cnt, m_res;
  bit m_done = 0, m_to = 0, m_busy = 0;
  bit d1 [4], d2 [4], d3 [4];

  always @(posedge clk) begin
    bit rs [4];
    bit r;
    cyc = cyc + 1;
    if (!rst_n) begin
      ph = 0; m_done = 0; m_to = 0; m_res = 0; m_busy = 0;
      for (int i = 0; i < 4; i++) begin d1[i] = 0; d2[i] = 0; d3[i] = 0; end
    end else begin
      for (int i = 0; i < 4; i++) rs[i] = d2[i] & ~d3[i];
      r = rs[m_sel];
      m_done = 0;
      if (ph == 0) begin
        if (start) begin
          m_sel = src_sel; m_left = cycles;
          m_lim = longint'(cycles) << ((src_sel == 3) ? SLO : SHI);
          if (m_lim > MAXC) m_lim = MAXC;
          m_el = 0; m_cnt = 0; m_res = 0; m_to = 0;
          if (cycles == 0) m_done = 1; else ph = 1;
        end
      end else begin
        if (ph == 2 && r && m_left == 1) begin
          m_res = (m_cnt + 1 > MAXC) ? MAXC : m_cnt + 1; m_done = 1; ph = 0;
        end else if (m_el >= m_lim) begin
          m_to = 1; m_res = 0; m_done = 1; ph = 0;
        end else if (ph == 1) begin
          if (r) ph = 2;
        end else begin
          m_cnt = m_cnt + 1;
          if (r) m_left = m_left - 1;
        end
        m_el = m_el + 1;
      end
      m_busy = (ph != 0);
      for (int i = 0; i < 4; i++) begin d3[i] = d2[i]; d2[i] = d1[i]; d1[i] = slow[i]; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks = checks + 1;
      if (busy !== m_busy || done !== m_done || timed_out !== m_to ||
          longint'(result) != m_res) begin
        errors = errors + 1;
        $display("FAIL R3 R5 R6 R9 model cycle %0d: busy %b done %b to %b res %0d, expected %b %b %b %0d",
                 cyc, busy, done, timed_out, result, m_busy, m_done, m_to, m_res);
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int sel, input int n, output int lat);
    src_sel = 2'(sel); cycles = CYC_W'(n); start = 1'b1;
    @(negedge clk); start = 1'b0; lat = 1;
    while (!done && lat < 150000) begin @(negedge clk); lat = lat + 1; end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    check("R1 done", done, 0); check("R1 busy", busy, 0);
    check("R1 timed_out", timed_out, 0); check("R1 result", result, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3: each source, distinct period
    run(0, 4, lat); check("R2 R3 src0", result, 4 * 8);  check("R3 src0 to", timed_out, 0);
    run(1, 3, lat); check("R2 R3 src1", result, 3 * 20);
    run(2, 2, lat); check("R2 R3 src2", result, 2 * 32);
    run(3, 5, lat); check("R2 R3 src3", result, 5 * 6);

    // R6: hold after done
    repeat (10) @(negedge clk);
    check("R6 hold result", result, 30); check("R6 done low", done, 0);

    // R4: same slow period, high shift passes, low shift times out
    half[1] = 20; half[3] = 20;
    repeat (50) @(negedge clk);
    run(1, 2, lat); check("R4 src1 passes", result, 80); check("R4 src1 no to", timed_out, 0);
    run(3, 2, lat); check("R4 src3 times out", timed_out, 1); check("R5 zero", result, 0);
    check("R5 latency", lat, (2 << SLO) + 2);

    // R5: dead crystal
    freeze[2] = 1;
    run(2, 3, lat); check("R5 dead to", timed_out, 1); check("R5 dead result", result, 0);
    check("R5 dead latency", lat, (3 << SHI) + 2);
    freeze[2] = 0;

    // R7: start while busy ignored
    src_sel = 2'd1; cycles = 2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 busy during run", busy, 1);
    src_sel = 2'd3; cycles = 1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin @(negedge clk); lat = lat + 1; end
    check("R7 result kept", result, 80); check("R7 no to", timed_out, 0);
    @(negedge clk); check("R9 busy low after", busy, 0);

    // R8: zero request
    run(0, 0, lat); check("R8 latency", lat, 1); check("R8 result", result, 0);
    check("R8 to", timed_out, 0);

    // R4: clamped threshold
    freeze[0] = 1;
    run(0, 2000, lat); check("R4 clamp to", timed_out, 1);
    check("R4 clamp latency", lat, int'(MAXC) + 2);
    freeze[0] = 0;
    repeat (20) @(negedge clk);
    finish_run();
  end

  initial begin
    wait (cyc > 190000);
    errors = errors + 1;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    finish_run();
  end
endmodule